// File: doc/BRIEF.md
# TDM Control and Bearer Timeslot Multiplexer

This block sits on a 32-timeslot serial TDM stream that runs one bit cell per clock cycle. A frame pulse marks the first bit cell of a frame, and each timeslot is eight bit cells long. Timeslot 1 carries a control/status byte. Timeslots 2 and 3 carry two bearer PCM channels. Timeslot 0 belongs to another block. Timeslots 4 to 31 are left alone. The output is modelled as a data bit plus a drive enable, and the drive enable decides which timeslots the block actually drives.

A small register port holds the outgoing control byte, the captured incoming control byte and a configuration register. The configuration register has a control enable and independent transmit and receive bearer selects. The local PCM side hands over one transmit byte per frame. It receives one byte per frame from the selected bearer timeslot, together with a single-cycle valid strobe.

Top module: `tdm_ctl_bearer_mux`

## Requirements
- R1: After reset, ser_oe and pcm_rx_vld are low, the configuration register at address 03h reads 0, and the transmit control byte is all ones, so it is sent as FFh once enabled.
- R2: The cycle in which frm_sync is high is bit cell 0 of timeslot 0. A timeslot is 8 cells and a frame is 32 timeslots. Timing wraps on its own when no pulse comes and restarts on every pulse. ser_oe stays low until the first pulse after reset.
- R3: In timeslot 1 with the control enable (configuration bit 0) at 1, the block drives the byte last written to address 05h, MSB in bit cell 0. With the enable at 0, timeslot 1 is not driven.
- R4: The byte received in timeslot 1, MSB first, is readable at address 05h from the cycle after the timeslot's last bit cell, whatever the control enable is set to.
- R5: Transmit select (configuration bits 2:1) works as follows: 01 drives timeslot 2, 10 drives timeslot 3, and 00 or 11 drives neither. The byte sent is pcm_tx as sampled in bit cell 0 of timeslot 0, MSB first. A bearer timeslot that is not selected is not driven.
- R6: Receive select (configuration bits 4:3) uses the same coding. pcm_rx takes the byte of the selected timeslot, and pcm_rx_vld is high for exactly the cycle after that timeslot's last bit cell. With 00 or 11 there is no strobe.
- R7: Timeslots 0 and 4 to 31 are never driven. ser_in in those timeslots reaches neither pcm_rx nor the register at 05h.
- R8: A write to address 03h with bit 7 set is a soft reset. It returns the transmit control byte to all ones and the configuration bits to 0, and it keeps the received control byte.
- R9: Reads are combinational. Address 03h returns {3'b000, receive select, transmit select, enable}, address 05h returns the received control byte, and any other address returns 0. Writes take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-cell clock, one cell per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_sync | input | 1 | High in the first bit cell of a frame |
| ser_in | input | 1 | Serial receive stream |
| ser_out | output | 1 | Serial transmit data, valid when ser_oe is high |
| ser_oe | output | 1 | Drive enable for ser_out; low means high impedance |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 8 | Register address |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data |
| pcm_tx | input | 8 | Local bearer byte to transmit |
| pcm_rx | output | 8 | Local bearer byte received |
| pcm_rx_vld | output | 1 | One-cycle strobe marking a new pcm_rx |

## Verification
The assertions rely on a few properties of the inputs. frm_sync is a single-cycle pulse, although it may come at any phase. At most one register write happens per cycle. pcm_tx only matters in the cell where it is sampled. The bench drives every input one nanosecond after the rising edge and samples on the falling edge, so no input changes close to an edge. It also issues one write at a time. Some frame pulses are deliberately dropped or moved off their usual phase, to cover both free-running wrap and resynchronisation.

// File: rtl/tdm_mux_pkg.sv
package tdm_mux_pkg;

   // bearer select coding, shared by the transmit and receive fields
   typedef enum logic [1:0] {
      BSEL_OFF     = 2'd0,
      BSEL_FIRST   = 2'd1,
      BSEL_SECOND  = 2'd2,
      BSEL_OFF_ALT = 2'd3
   } bsel_e;

   // configuration register image: [4:3] rx select, [2:1] tx select, [0] control enable
   typedef struct packed {
      bsel_e rx_sel;
      bsel_e tx_sel;
      logic  ctrl_en;
   } cfg_t;

   localparam int CFG_W       = $bits(cfg_t);
   localparam int NUM_BEARERS = 2;

   function automatic bsel_e bearer_code(input int idx);
      return (idx == 0) ? BSEL_FIRST : BSEL_SECOND;
   endfunction

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
   parameter int BIT_W     = 8,
   parameter int NUM_SLOTS = 32,
   localparam int BCNT_W   = $clog2(BIT_W),
   localparam int SCNT_W   = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_sync,
   output logic [BCNT_W-1:0] bit_idx,
   output logic [SCNT_W-1:0] slot_idx,
   output logic              synced,
   output logic              slot_last,
   output logic              frame_start
);

   localparam logic [BCNT_W-1:0] LAST_BIT  = BCNT_W'(BIT_W - 1);
   localparam logic [SCNT_W-1:0] LAST_SLOT = SCNT_W'(NUM_SLOTS - 1);

   logic [BCNT_W-1:0] bit_q;
   logic [SCNT_W-1:0] slot_q;
   logic              sync_q;

   // a frame pulse forces the current cell to slot 0 / bit 0
   always_comb begin
      bit_idx     = frm_sync ? '0 : bit_q;
      slot_idx    = frm_sync ? '0 : slot_q;
      synced      = sync_q | frm_sync;
      slot_last   = synced && (bit_idx == LAST_BIT);
      frame_start = synced && (bit_idx == '0) && (slot_idx == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_q  <= '0;
         slot_q <= '0;
         sync_q <= 1'b0;
      end else begin
         sync_q <= synced;
         if (bit_idx == LAST_BIT) begin
            bit_q  <= '0;
            slot_q <= (slot_idx == LAST_SLOT) ? '0 : slot_idx + SCNT_W'(1);
         end else begin
            bit_q  <= bit_idx + BCNT_W'(1);
            slot_q <= slot_idx;
         end
      end
   end

endmodule

// File: rtl/tdm_cfg_regs.sv
module tdm_cfg_regs
   import tdm_mux_pkg::*;
#(
   parameter int BIT_W     = 8,
   parameter int ADDR_W    = 8,
   parameter int CTRL_ADDR = 5,
   parameter int CFG_ADDR  = 3,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [BIT_W-1:0]  cpu_wdata,
   output logic [BIT_W-1:0]  cpu_rdata,
   input  logic              cap_en,
   input  logic [BIT_W-1:0]  cap_data,
   output logic [BIT_W-1:0]  tx_ctrl,
   output cfg_t              cfg
);

   localparam int SRST_BIT = BIT_W - 1;
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_ADDR);

   logic [BIT_W-1:0] tx_ctrl_q;
   logic [BIT_W-1:0] rx_ctrl_q;
   cfg_t             cfg_q;
   logic [BIT_W-1:0] rd_next;
   logic             wr_ctrl, wr_cfg;

   assign wr_ctrl = cpu_wr && (cpu_addr == A_CTRL);
   assign wr_cfg  = cpu_wr && (cpu_addr == A_CFG);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_ctrl_q <= '1;
         cfg_q     <= '0;
      end else if (wr_cfg && cpu_wdata[SRST_BIT]) begin
         tx_ctrl_q <= '1;
         cfg_q     <= '0;
      end else if (wr_cfg) begin
         cfg_q <= cfg_t'(cpu_wdata[CFG_W-1:0]);
      end else if (wr_ctrl) begin
         tx_ctrl_q <= cpu_wdata;
      end
   end

   // receive side is loaded every frame, independent of the enable
   always_ff @(posedge clk) begin
      if (!rst_n)      rx_ctrl_q <= '0;
      else if (cap_en) rx_ctrl_q <= cap_data;
   end

   always_comb begin
      rd_next = '0;
      if (cpu_addr == A_CTRL)     rd_next = rx_ctrl_q;
      else if (cpu_addr == A_CFG) rd_next[CFG_W-1:0] = cfg_q;
   end

   generate
      if (RDATA_REG) begin : g_rd_reg
         logic [BIT_W-1:0] rdata_q;
         always_ff @(posedge clk) begin
            if (!rst_n) rdata_q <= '0;
            else        rdata_q <= rd_next;
         end
         assign cpu_rdata = rdata_q;
      end else begin : g_rd_comb
         assign cpu_rdata = rd_next;
      end
   endgenerate

   assign tx_ctrl = tx_ctrl_q;
   assign cfg     = cfg_q;

endmodule

// File: rtl/tdm_tx_path.sv
module tdm_tx_path
   import tdm_mux_pkg::*;
#(
   parameter int BIT_W     = 8,
   parameter int NUM_SLOTS = 32,
   parameter int CTRL_SLOT = 1,
   parameter int B1_SLOT   = 2,
   parameter int B2_SLOT   = 3,
   localparam int BCNT_W   = $clog2(BIT_W),
   localparam int SCNT_W   = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BCNT_W-1:0] bit_idx,
   input  logic [SCNT_W-1:0] slot_idx,
   input  logic              synced,
   input  logic              frame_start,
   input  logic              ctrl_en,
   input  bsel_e             tx_sel,
   input  logic [BIT_W-1:0]  tx_ctrl,
   input  logic [BIT_W-1:0]  pcm_tx,
   output logic              ser_out,
   output logic              ser_oe
);

   localparam logic [BCNT_W-1:0] MSB_IDX = BCNT_W'(BIT_W - 1);

   logic [BIT_W-1:0]       pcm_hold_q;
   logic [NUM_BEARERS-1:0] b_hit;
   logic                   ctrl_hit;
   logic [BIT_W-1:0]       cur_byte;

   // bearer byte is latched once per frame, at the first cell
   always_ff @(posedge clk) begin
      if (!rst_n)           pcm_hold_q <= '0;
      else if (frame_start) pcm_hold_q <= pcm_tx;
   end

   generate
      for (genvar i = 0; i < NUM_BEARERS; i++) begin : g_bear
         localparam int SLOT_I = (i == 0) ? B1_SLOT : B2_SLOT;
         assign b_hit[i] = (tx_sel == bearer_code(i)) &&
                           (slot_idx == SCNT_W'(SLOT_I));
      end
   endgenerate

   assign ctrl_hit = ctrl_en && (slot_idx == SCNT_W'(CTRL_SLOT));
   assign cur_byte = ctrl_hit ? tx_ctrl : pcm_hold_q;
   assign ser_oe   = synced && (ctrl_hit || (|b_hit));
   assign ser_out  = ser_oe ? cur_byte[MSB_IDX - bit_idx] : 1'b0;

endmodule

// File: rtl/tdm_rx_path.sv
module tdm_rx_path
   import tdm_mux_pkg::*;
#(
   parameter int BIT_W     = 8,
   parameter int NUM_SLOTS = 32,
   parameter int CTRL_SLOT = 1,
   parameter int B1_SLOT   = 2,
   parameter int B2_SLOT   = 3,
   localparam int SCNT_W   = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_in,
   input  logic [SCNT_W-1:0] slot_idx,
   input  logic              slot_last,
   input  bsel_e             rx_sel,
   output logic              ctrl_cap,
   output logic [BIT_W-1:0]  cap_byte,
   output logic [BIT_W-1:0]  pcm_rx,
   output logic              pcm_rx_vld
);

   logic [BIT_W-1:0]       sh_q;
   logic [NUM_BEARERS-1:0] b_hit;
   logic [BIT_W-1:0]       pcm_q;
   logic                   vld_q;

   assign cap_byte = {sh_q[BIT_W-2:0], ser_in};
   assign ctrl_cap = slot_last && (slot_idx == SCNT_W'(CTRL_SLOT));

   generate
      for (genvar i = 0; i < NUM_BEARERS; i++) begin : g_bear
         localparam int SLOT_I = (i == 0) ? B1_SLOT : B2_SLOT;
         assign b_hit[i] = slot_last && (rx_sel == bearer_code(i)) &&
                           (slot_idx == SCNT_W'(SLOT_I));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q  <= '0;
         pcm_q <= '0;
         vld_q <= 1'b0;
      end else begin
         sh_q  <= cap_byte;
         vld_q <= |b_hit;
         if (|b_hit) pcm_q <= cap_byte;
      end
   end

   assign pcm_rx     = pcm_q;
   assign pcm_rx_vld = vld_q;

endmodule

// File: rtl/tdm_ctl_bearer_mux.sv
module tdm_ctl_bearer_mux
   import tdm_mux_pkg::*;
#(
   parameter int BIT_W     = 8,
   parameter int NUM_SLOTS = 32,
   parameter int ADDR_W    = 8,
   parameter int CTRL_ADDR = 5,
   parameter int CFG_ADDR  = 3,
   parameter int CTRL_SLOT = 1,
   parameter int B1_SLOT   = 2,
   parameter int B2_SLOT   = 3,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_sync,
   input  logic              ser_in,
   output logic              ser_out,
   output logic              ser_oe,
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [BIT_W-1:0]  cpu_wdata,
   output logic [BIT_W-1:0]  cpu_rdata,
   input  logic [BIT_W-1:0]  pcm_tx,
   output logic [BIT_W-1:0]  pcm_rx,
   output logic              pcm_rx_vld
);

   localparam int BCNT_W = $clog2(BIT_W);
   localparam int SCNT_W = $clog2(NUM_SLOTS);

   // elaboration-time parameter checks
   if (BIT_W < CFG_W + 2) begin : g_bad_width
      $error("BIT_W too small for configuration field and soft reset bit");
   end
   if (NUM_SLOTS < 4) begin : g_bad_slots
      $error("NUM_SLOTS must be at least 4");
   end
   if (CTRL_SLOT == B1_SLOT || CTRL_SLOT == B2_SLOT || B1_SLOT == B2_SLOT) begin : g_bad_map
      $error("control and bearer timeslots must differ");
   end
   if (CTRL_SLOT >= NUM_SLOTS || B1_SLOT >= NUM_SLOTS || B2_SLOT >= NUM_SLOTS) begin : g_bad_range
      $error("timeslot index out of range");
   end
   if (CTRL_ADDR == CFG_ADDR || CTRL_ADDR >= (1 << ADDR_W) || CFG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("register addresses must differ and fit ADDR_W");
   end

   logic [BCNT_W-1:0] bit_idx;
   logic [SCNT_W-1:0] slot_idx;
   logic              synced, slot_last, frame_start;
   logic              ctrl_cap;
   logic [BIT_W-1:0]  cap_byte;
   logic [BIT_W-1:0]  tx_ctrl_q;
   cfg_t              cfg_q;

   tdm_slot_timer #(
      .BIT_W     (BIT_W),
      .NUM_SLOTS (NUM_SLOTS)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .frm_sync    (frm_sync),
      .bit_idx     (bit_idx),
      .slot_idx    (slot_idx),
      .synced      (synced),
      .slot_last   (slot_last),
      .frame_start (frame_start)
   );

   tdm_cfg_regs #(
      .BIT_W     (BIT_W),
      .ADDR_W    (ADDR_W),
      .CTRL_ADDR (CTRL_ADDR),
      .CFG_ADDR  (CFG_ADDR),
      .RDATA_REG (RDATA_REG)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_wr    (cpu_wr),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .cpu_rdata (cpu_rdata),
      .cap_en    (ctrl_cap),
      .cap_data  (cap_byte),
      .tx_ctrl   (tx_ctrl_q),
      .cfg       (cfg_q)
   );

   tdm_tx_path #(
      .BIT_W     (BIT_W),
      .NUM_SLOTS (NUM_SLOTS),
      .CTRL_SLOT (CTRL_SLOT),
      .B1_SLOT   (B1_SLOT),
      .B2_SLOT   (B2_SLOT)
   ) u_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_idx     (bit_idx),
      .slot_idx    (slot_idx),
      .synced      (synced),
      .frame_start (frame_start),
      .ctrl_en     (cfg_q.ctrl_en),
      .tx_sel      (cfg_q.tx_sel),
      .tx_ctrl     (tx_ctrl_q),
      .pcm_tx      (pcm_tx),
      .ser_out     (ser_out),
      .ser_oe      (ser_oe)
   );

   tdm_rx_path #(
      .BIT_W     (BIT_W),
      .NUM_SLOTS (NUM_SLOTS),
      .CTRL_SLOT (CTRL_SLOT),
      .B1_SLOT   (B1_SLOT),
      .B2_SLOT   (B2_SLOT)
   ) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .ser_in     (ser_in),
      .slot_idx   (slot_idx),
      .slot_last  (slot_last),
      .rx_sel     (cfg_q.rx_sel),
      .ctrl_cap   (ctrl_cap),
      .cap_byte   (cap_byte),
      .pcm_rx     (pcm_rx),
      .pcm_rx_vld (pcm_rx_vld)
   );

endmodule

// File: rtl/tdm_ctl_bearer_mux_chk.sv
module tdm_ctl_bearer_mux_chk #(
   parameter int BIT_W     = 8,
   parameter int NUM_SLOTS = 32,
   parameter int ADDR_W    = 8,
   parameter int CTRL_ADDR = 5,
   parameter int CFG_ADDR  = 3,
   parameter int CTRL_SLOT = 1,
   parameter int B1_SLOT   = 2,
   parameter int B2_SLOT   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frm_sync,
   input logic              ser_in,
   input logic              ser_oe,
   input logic              pcm_rx_vld,
   input logic              cpu_wr,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [BIT_W-1:0]  cpu_wdata,
   input logic              ctrl_en,
   input logic [BIT_W-1:0]  tx_ctrl,
   input logic [BIT_W-1:0]  rx_ctrl
);

   localparam int FRAME = BIT_W * NUM_SLOTS;
   localparam int POS_W = $clog2(FRAME);

   logic [POS_W-1:0] pos_q, pos_c;
   logic             seen_q, seen_c;
   int               slot_c, bit_c;
   logic [BIT_W-1:0] sh_q, sh_n, cap_exp_q;
   logic             cap_q, bend_q;

   // independent frame position tracker
   always_comb begin
      pos_c  = frm_sync ? '0 : pos_q;
      seen_c = seen_q | frm_sync;
      slot_c = int'(pos_c) / BIT_W;
      bit_c  = int'(pos_c) % BIT_W;
      sh_n   = {sh_q[BIT_W-2:0], ser_in};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q     <= '0;
         seen_q    <= 1'b0;
         sh_q      <= '0;
         cap_q     <= 1'b0;
         cap_exp_q <= '0;
         bend_q    <= 1'b0;
      end else begin
         pos_q     <= (pos_c == POS_W'(FRAME - 1)) ? '0 : pos_c + POS_W'(1);
         seen_q    <= seen_c;
         sh_q      <= sh_n;
         cap_q     <= seen_c && (slot_c == CTRL_SLOT) && (bit_c == BIT_W - 1);
         cap_exp_q <= sh_n;
         bend_q    <= seen_c && (bit_c == BIT_W - 1) &&
                      ((slot_c == B1_SLOT) || (slot_c == B2_SLOT));
      end
   end

   // R2: nothing driven before the first frame pulse
   assert_unsynced_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_c |-> !ser_oe);

   // R7: unused timeslots never driven
   assert_idle_slots_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_c != CTRL_SLOT && slot_c != B1_SLOT && slot_c != B2_SLOT) |-> !ser_oe);

   // R3: control slot gated by enable
   assert_ctrl_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_c == CTRL_SLOT && !ctrl_en) |-> !ser_oe);

   // R3: a write to the control address lands in the transmit byte
   assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr == ADDR_W'(CTRL_ADDR)) |=> (tx_ctrl == $past(cpu_wdata)));

   // R4: received control byte captured at slot end
   assert_ctrl_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cap_q |-> (rx_ctrl == cap_exp_q));

   // R6: strobe is one cycle wide
   assert_vld_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pcm_rx_vld |=> !pcm_rx_vld);

   // R6: strobe only right after a bearer slot ends
   assert_vld_place_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pcm_rx_vld |-> bend_q);

   // R8: soft reset restores defaults
   assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr == ADDR_W'(CFG_ADDR) && cpu_wdata[BIT_W-1])
      |=> (tx_ctrl == '1 && !ctrl_en));

endmodule

bind tdm_ctl_bearer_mux tdm_ctl_bearer_mux_chk #(
   .BIT_W     (BIT_W),
   .NUM_SLOTS (NUM_SLOTS),
   .ADDR_W    (ADDR_W),
   .CTRL_ADDR (CTRL_ADDR),
   .CFG_ADDR  (CFG_ADDR),
   .CTRL_SLOT (CTRL_SLOT),
   .B1_SLOT   (B1_SLOT),
   .B2_SLOT   (B2_SLOT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frm_sync   (frm_sync),
   .ser_in     (ser_in),
   .ser_oe     (ser_oe),
   .pcm_rx_vld (pcm_rx_vld),
   .cpu_wr     (cpu_wr),
   .cpu_addr   (cpu_addr),
   .cpu_wdata  (cpu_wdata),
   .ctrl_en    (cfg_q.ctrl_en),
   .tx_ctrl    (tx_ctrl_q),
   .rx_ctrl    (u_regs.rx_ctrl_q)
);

// File: tb/tdm_ctl_bearer_mux_bench.sv
`timescale 1ns/100ps
module tdm_ctl_bearer_mux_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frm_sync = 1'b0;
   logic       ser_in = 1'b0;
   logic       ser_out, ser_oe;
   logic       cpu_wr = 1'b0;
   logic [7:0] cpu_addr = 8'h03;
   logic [7:0] cpu_wdata = 8'h00;
   logic [7:0] cpu_rdata;
   logic [7:0] pcm_tx = 8'h00;
   logic [7:0] pcm_rx;
   logic       pcm_rx_vld;

   always #2.5 clk = ~clk;

   tdm_ctl_bearer_mux u_tdm_ctl_bearer_mux (
      .clk(clk), .rst_n(rst_n), .frm_sync(frm_sync), .ser_in(ser_in),
      .ser_out(ser_out), .ser_oe(ser_oe), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pcm_tx(pcm_tx),
      .pcm_rx(pcm_rx), .pcm_rx_vld(pcm_rx_vld));

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   // reference model state
   int         m_pos;
   bit         m_sync, m_en, m_vld;
   int         m_txs, m_rxs;
   logic [7:0] m_txc, m_rxc, m_hold, m_sh, m_pcm;

   logic [7:0] rx_frame [32];
   logic [7:0] obs      [32];
   bit         oeseen   [32];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // compare on every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int cur, sl, bt, eb;
         bit sn, eoe;
         logic [7:0] erd;
         string req;
         cur = frm_sync ? 0 : m_pos;
         sl  = cur / 8;
         bt  = cur % 8;
         sn  = m_sync | frm_sync;
         eoe = sn && ((sl == 1 && m_en) || (sl == 2 && m_txs == 1) || (sl == 3 && m_txs == 2));
         req = !sn ? "R2" : (sl == 1) ? "R3" : (sl == 2 || sl == 3) ? "R5" : "R7";
         check(ser_oe == eoe, req, "ser_oe", ser_oe, eoe);
         if (eoe) begin
            eb = (sl == 1) ? m_txc[7-bt] : m_hold[7-bt];
            check(ser_out == eb, req, "ser_out bit", ser_out, eb);
         end
         if (ser_oe) begin
            obs[sl]    = {obs[sl][6:0], ser_out};
            oeseen[sl] = 1'b1;
         end
         check(pcm_rx_vld == m_vld, "R6", "pcm_rx_vld", pcm_rx_vld, m_vld);
         if (m_vld) check(pcm_rx == m_pcm, "R6", "pcm_rx", pcm_rx, m_pcm);
         erd = (cpu_addr == 8'h05) ? m_rxc :
               (cpu_addr == 8'h03) ? {3'b000, 2'(m_rxs), 2'(m_txs), m_en} : 8'h00;
         check(cpu_rdata == erd, (cpu_addr == 8'h05) ? "R4" : "R9", "cpu_rdata", cpu_rdata, erd);
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pos = 0; m_sync = 0; m_en = 0; m_vld = 0; m_txs = 0; m_rxs = 0;
         m_txc = 8'hFF; m_rxc = 8'h00; m_hold = 8'h00; m_sh = 8'h00; m_pcm = 8'h00;
      end else begin
         int cur, sl, bt;
         bit sn, nv;
         logic [7:0] nsh;
         cur = frm_sync ? 0 : m_pos;
         sl  = cur / 8;
         bt  = cur % 8;
         sn  = m_sync | frm_sync;
         nsh = {m_sh[6:0], ser_in};
         nv  = 1'b0;
         if (sn && bt == 7) begin
            if (sl == 1) m_rxc = nsh;
            if ((sl == 2 && m_rxs == 1) || (sl == 3 && m_rxs == 2)) begin
               nv = 1'b1;
               m_pcm = nsh;
            end
         end
         m_vld = nv;
         if (sn && cur == 0) m_hold = pcm_tx;
         if (cpu_wr && cpu_addr == 8'h05) m_txc = cpu_wdata;
         if (cpu_wr && cpu_addr == 8'h03) begin
            if (cpu_wdata[7]) begin
               m_txc = 8'hFF; m_en = 0; m_txs = 0; m_rxs = 0;
            end else begin
               m_en = cpu_wdata[0]; m_txs = cpu_wdata[2:1]; m_rxs = cpu_wdata[4:3];
            end
         end
         m_sh   = nsh;
         m_pos  = (cur + 1) % 256;
         m_sync = sn;
      end
   end

   task automatic step(input bit sync, input bit wr, input logic [7:0] wa, input logic [7:0] wd);
      int p;
      @(posedge clk);
      #1;
      frm_sync  = sync;
      p         = sync ? 0 : m_pos;
      ser_in    = rx_frame[p/8][7 - p%8];
      cpu_wr    = wr;
      cpu_addr  = wa;
      cpu_wdata = wd;
   endtask

   task automatic clear_obs();
      for (int i = 0; i < 32; i++) begin
         obs[i] = 8'h00;
         oeseen[i] = 1'b0;
      end
   endtask

   task automatic run_frame(input bit sync, input logic [7:0] ra);
      clear_obs();
      step(sync, 1'b0, ra, 8'h00);
      for (int c = 1; c < 256; c++) step(1'b0, 1'b0, ra, 8'h00);
   endtask

   task automatic fill_rx(input int seed);
      for (int i = 0; i < 32; i++) rx_frame[i] = 8'(seed * 37 + i * 91 + 5);
   endtask

   initial begin
      #(5.0 * 190000);
      if (!done) begin
         done = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      fill_rx(1);
      repeat (4) @(posedge clk);
      #1;
      rst_n = 1'b1;
      #1;
      // R1: reset state
      check(ser_oe == 1'b0, "R1", "ser_oe after reset", ser_oe, 0);
      check(pcm_rx_vld == 1'b0, "R1", "pcm_rx_vld after reset", pcm_rx_vld, 0);
      check(cpu_rdata == 8'h00, "R1", "config after reset", cpu_rdata, 0);

      // R2: no drive before first frame pulse, even once enabled
      step(1'b0, 1'b1, 8'h03, 8'h01);
      for (int c = 0; c < 40; c++) step(1'b0, 1'b0, 8'h07, 8'h00);

      // R1: default control byte goes out as all ones
      run_frame(1'b1, 8'h03);
      check(oeseen[1] && obs[1] == 8'hFF, "R1", "default control byte", obs[1], 8'hFF);

      // R3/R5/R6: control byte, bearer B1 out, bearer B2 in
      fill_rx(2);
      rx_frame[3] = 8'h96;
      pcm_tx = 8'h3C;
      step(1'b0, 1'b1, 8'h05, 8'hA5);
      step(1'b0, 1'b1, 8'h03, 8'h13);
      for (int c = 0; c < 254; c++) step(1'b0, 1'b0, 8'h03, 8'h00);
      run_frame(1'b1, 8'h05);
      check(obs[1] == 8'hA5, "R3", "control byte sent", obs[1], 8'hA5);
      check(oeseen[2] && obs[2] == 8'h3C, "R5", "B1 byte sent", obs[2], 8'h3C);
      check(!oeseen[3], "R5", "B2 undriven", oeseen[3], 0);
      check(pcm_rx == 8'h96, "R6", "B2 byte received", pcm_rx, 8'h96);
      check(cpu_rdata == rx_frame[1], "R4", "control byte received", cpu_rdata, rx_frame[1]);

      // R3/R4: enable low, capture still happens; swap bearer selects
      fill_rx(3);
      rx_frame[1] = 8'h3C;
      rx_frame[2] = 8'h5A;
      pcm_tx = 8'hC3;
      step(1'b0, 1'b1, 8'h03, 8'h0C);
      run_frame(1'b1, 8'h05);
      check(!oeseen[1], "R3", "control slot undriven with enable low", oeseen[1], 0);
      check(obs[3] == 8'hC3, "R5", "B2 byte sent", obs[3], 8'hC3);
      check(pcm_rx == 8'h5A, "R6", "B1 byte received", pcm_rx, 8'h5A);
      check(cpu_rdata == 8'h3C, "R4", "capture with enable low", cpu_rdata, 8'h3C);

      // R5/R6/R7: select code 11 means no bearer; other slots carry noise
      fill_rx(4);
      step(1'b0, 1'b1, 8'h03, 8'h1F);
      run_frame(1'b1, 8'h03);
      check(!oeseen[2] && !oeseen[3], "R5", "no bearer driven for code 11", oeseen[2] | oeseen[3], 0);
      check(!oeseen[0] && !oeseen[4] && !oeseen[31], "R7", "idle slots undriven", oeseen[0], 0);
      check(pcm_rx == 8'h5A, "R7", "pcm_rx untouched by idle slots", pcm_rx, 8'h5A);

      // R8: soft reset keeps the captured byte
      step(1'b0, 1'b1, 8'h05, 8'h42);
      step(1'b0, 1'b1, 8'h03, 8'h80);
      step(1'b0, 1'b0, 8'h03, 8'h00);
      #1;
      check(cpu_rdata == 8'h00, "R8", "config after soft reset", cpu_rdata, 0);
      step(1'b0, 1'b0, 8'h05, 8'h00);
      #1;
      check(cpu_rdata == rx_frame[1], "R8", "received byte kept", cpu_rdata, rx_frame[1]);
      step(1'b0, 1'b1, 8'h03, 8'h01);
      run_frame(1'b1, 8'h07);
      check(obs[1] == 8'hFF, "R8", "control byte back to ones", obs[1], 8'hFF);
      check(cpu_rdata == 8'h00, "R9", "unmapped address", cpu_rdata, 0);

      // R2: resynchronise mid-frame
      for (int c = 0; c < 100; c++) step(1'b0, 1'b0, 8'h05, 8'h00);
      run_frame(1'b1, 8'h03);
      check(obs[1] == 8'hFF, "R2", "resync control slot", obs[1], 8'hFF);

      // mixed traffic, random writes, dropped and shifted pulses
      for (int f = 0; f < 40; f++) begin
         int wat, gap;
         logic [7:0] wa, wd, ra;
         fill_rx(f + 10);
         pcm_tx = 8'($urandom);
         wat = $urandom % 256;
         gap = $urandom % 20;
         wa  = ($urandom % 2) ? 8'h03 : 8'h05;
         wd  = 8'($urandom);
         if (wa == 8'h03 && ($urandom % 4) != 0) wd[7] = 1'b0;
         for (int c = 0; c < gap; c++) step(1'b0, 1'b0, 8'h05, 8'h00);
         for (int c = 0; c < 256; c++) begin
            ra = (c % 3 == 0) ? 8'h03 : (c % 3 == 1) ? 8'h05 : 8'h11;
            step(c == 0 && (f % 5) != 4, c == wat, (c == wat) ? wa : ra, wd);
         end
      end

      step(1'b0, 1'b0, 8'h03, 8'h00);
      @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule